// File: doc/BRIEF.md
# Masked Pixel Colour Lookup Path

This block sits between a scan-out engine and a video output stage. Every pixel clock it takes an 8-bit pixel index and forms a table address by clearing the index bits that a programmable mask removes. It presents that address on the read port of an external colour table, which is a synchronous RAM that returns a 24-bit word one clock later. The block then registers that word as red, green and blue bytes.

A component-width mode is captured while reset is held. In narrow mode each stored 6-bit component is widened to a full byte by repeating its top bits. In full mode the stored byte passes through unchanged. The horizontal and vertical sync inputs are carried down a pipeline as long as the colour path, so they stay aligned with the pixel data. Each sync takes its output polarity from a control byte. A further control bit drives a static output pin.

Top module: `px_lookup_path`

## Requirements
- R1: `lut_addr` equals `pix_idx & pix_mask` in the same cycle, with no register on the way. The table answers it on `lut_rdata` after the next rising clock edge.
- R2: While `rst_n` is low, each rising edge captures the width mode. A `width_req` of 8 selects full-byte mode, and every other value selects 6-bit mode. Changes on `width_req` while `rst_n` is high have no effect on the output.
- R3: In 6-bit mode each output component is `{c[5:0], c[5:4]}`, where `c` is the stored byte. Bits 7:6 of the stored byte have no effect on the output.
- R4: In full-byte mode each output component equals the stored byte. Red is `lut_rdata[23:16]`, green is `[15:8]` and blue is `[7:0]`, and `rgb_out` uses the same layout.
- R5: `gen_ctrl[0]` sets the horizontal sync polarity. With 1, `hsync_out` follows `hsync_in` (active-high); with 0 it is the inverse.
- R6: `gen_ctrl[1]` sets the vertical sync polarity in the same way for `vsync_out`.
- R7: `mux_out` equals `gen_ctrl[7]` combinationally at all times.
- R8: `rgb_out`, `hsync_out` and `vsync_out` reflect the inputs sampled two rising edges earlier. The polarity bits are sampled on the same edge as the sync they apply to.
- R9: While `rst_n` is low, `rgb_out`, `hsync_out` and `vsync_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset; asynchronous for the pipeline, and captures the width mode |
| width_req | input | 4 | Requested component width, sampled during reset |
| pix_idx | input | 8 | Incoming pixel index |
| pix_mask | input | 8 | Read mask applied to the index |
| gen_ctrl | input | 8 | Control byte: bit 0 hsync polarity, bit 1 vsync polarity, bit 7 static pin |
| hsync_in | input | 1 | Horizontal sync, active-high |
| vsync_in | input | 1 | Vertical sync, active-high |
| lut_addr | output | 8 | Colour table read address |
| lut_rdata | input | 24 | Colour table read data, one clock after the address |
| rgb_out | output | 24 | Registered colour output |
| hsync_out | output | 1 | Delayed horizontal sync with polarity applied |
| vsync_out | output | 1 | Delayed vertical sync with polarity applied |
| mux_out | output | 1 | Static pin driven by control bit 7 |

## Verification
The hardest case to reach is the width mode. It can change only during a reset, so a single run never sees both expansions or the rule that replaces an unsupported width. The stimulus therefore resets the block several times, once each with a request of 8, 7 and 6. After each release it drives random values onto `width_req`, and the output must ignore them. The colour table contents keep bits 7:6 busy, so widening the wrong bits shows up in the bytes.

// File: rtl/px_lut_pkg.sv
package px_lut_pkg;
  localparam int CH_W   = 8;              // output component width
  localparam int NARROW = 6;              // stored width in narrow mode
  localparam int FILL_W = CH_W - NARROW;  // bits replicated on widening
  localparam int N_CH   = 3;              // red, green, blue
  localparam int RGB_W  = N_CH * CH_W;
  localparam int REQ_W  = 4;

  typedef logic [CH_W-1:0] chan_t;
  typedef logic [N_CH-1:0][CH_W-1:0] rgb_t;   // [2]=red [1]=green [0]=blue

  typedef enum logic {
    CW_NARROW = 1'b0,
    CW_FULL   = 1'b1
  } cwidth_e;

  // any request other than a full byte falls back to the narrow width
  function automatic cwidth_e decode_width(input logic [REQ_W-1:0] req);
    return (req == REQ_W'(CH_W)) ? CW_FULL : CW_NARROW;
  endfunction

  // widen a narrow component by repeating its top bits underneath
  function automatic chan_t widen_narrow(input chan_t c);
    return {c[NARROW-1:0], c[NARROW-1 -: FILL_W]};
  endfunction

  // sync inputs are active-high; a clear polarity bit inverts
  function automatic logic polarize(input logic s, input logic pol);
    return pol ? s : ~s;
  endfunction
endpackage

// File: rtl/px_index_mask.sv
module px_index_mask #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] pix_idx,
  input  logic [IDX_W-1:0] pix_mask,
  output logic [IDX_W-1:0] tbl_addr
);
  always_comb tbl_addr = pix_idx & pix_mask;
endmodule

// File: rtl/px_width_latch.sv
module px_width_latch
  import px_lut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_W-1:0] width_req,
  output cwidth_e          mode
);
  // loaded only while reset is held, so the mode is fixed for a session
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= decode_width(width_req);
  end
endmodule

// File: rtl/px_colour_stage.sv
module px_colour_stage
  import px_lut_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cwidth_e mode,
  input  rgb_t    raw,
  output rgb_t    shaped,
  output rgb_t    rgb_q
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_comb shaped[c] = (mode == CW_FULL) ? raw[c] : widen_narrow(raw[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rgb_q <= '0;
    else        rgb_q <= shaped;
  end
endmodule

// File: rtl/px_sync_pipe.sv
module px_sync_pipe
  import px_lut_pkg::*;
#(
  parameter int N_SYNC = 2,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SYNC-1:0] sync_in,
  input  logic [N_SYNC-1:0] pol,
  output logic [N_SYNC-1:0] sync_mid,
  output logic [N_SYNC-1:0] sync_out
);
  logic [N_SYNC-1:0] st [DEPTH];
  logic [N_SYNC-1:0] adj;

  for (genvar s = 0; s < N_SYNC; s++) begin : g_pol
    always_comb adj[s] = polarize(sync_in[s], pol[s]);
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_st
    if (d == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[0] <= '0;
        else        st[0] <= adj;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[d] <= '0;
        else        st[d] <= st[d-1];
      end
    end
  end

  assign sync_mid = st[0];
  assign sync_out = st[DEPTH-1];
endmodule

// File: rtl/px_lookup_path.sv
module px_lookup_path
  import px_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       width_req,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic [IDX_W-1:0] pix_mask,
  input  logic [7:0]       gen_ctrl,
  input  logic             hsync_in,
  input  logic             vsync_in,
  output logic [IDX_W-1:0] lut_addr,
  input  logic [23:0]      lut_rdata,
  output logic [23:0]      rgb_out,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic             mux_out
);
  localparam int TBL_LAT   = 1;                // synchronous table read
  localparam int LAT       = TBL_LAT + 1;      // plus the colour register
  localparam int N_SYNC    = 2;
  localparam int HPOL_BIT  = 0;
  localparam int VPOL_BIT  = 1;
  localparam int MUX_BIT   = 7;

  // named internal events, brought out for the checker
  cwidth_e           wide_mode;
  rgb_t              shaped_rgb;
  rgb_t              rgb_q;
  logic [N_SYNC-1:0] sync_mid;
  logic [N_SYNC-1:0] sync_q;

  px_index_mask #(.IDX_W(IDX_W)) i_mask (
    .pix_idx  (pix_idx),
    .pix_mask (pix_mask),
    .tbl_addr (lut_addr)
  );

  px_width_latch i_width (
    .clk       (clk),
    .rst_n     (rst_n),
    .width_req (width_req),
    .mode      (wide_mode)
  );

  px_colour_stage i_colour (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (wide_mode),
    .raw    (rgb_t'(lut_rdata)),
    .shaped (shaped_rgb),
    .rgb_q  (rgb_q)
  );

  px_sync_pipe #(.N_SYNC(N_SYNC), .DEPTH(LAT)) i_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  ({vsync_in, hsync_in}),
    .pol      ({gen_ctrl[VPOL_BIT], gen_ctrl[HPOL_BIT]}),
    .sync_mid (sync_mid),
    .sync_out (sync_q)
  );

  assign rgb_out   = rgb_q;
  assign hsync_out = sync_q[0];
  assign vsync_out = sync_q[1];
  assign mux_out   = gen_ctrl[MUX_BIT];
endmodule

// File: rtl/px_lookup_path_chk.sv
module px_lookup_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  pix_idx,
  input logic [7:0]  pix_mask,
  input logic [7:0]  gen_ctrl,
  input logic        hsync_in,
  input logic        vsync_in,
  input logic [7:0]  lut_addr,
  input logic [23:0] lut_rdata,
  input logic [23:0] rgb_out,
  input logic        hsync_out,
  input logic        vsync_out,
  input logic        wide_mode
);
  // edges seen with reset released, saturating
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1
  addr_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lut_addr & ~pix_mask) == 8'h00) && ((lut_addr & ~pix_idx) == 8'h00));

  // R2
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm >= 2'd1) |-> $stable(wide_mode));

  // R3
  narrow_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && warm >= 2'd2) |->
      (rgb_out[1:0] == rgb_out[7:6]) && (rgb_out[9:8] == rgb_out[15:14]) &&
      (rgb_out[17:16] == rgb_out[23:22]));

  // R4
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && warm >= 2'd2) |-> (rgb_out == $past(lut_rdata)));

  // R5
  hsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (hsync_out == ($past(hsync_in, 2) ^ !$past(gen_ctrl[0], 2))));

  // R6
  vsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (vsync_out == ($past(vsync_in, 2) ^ !$past(gen_ctrl[1], 2))));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (rgb_out == 24'h0 && !hsync_out && !vsync_out));
endmodule

bind px_lookup_path px_lookup_path_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_idx   (pix_idx),
  .pix_mask  (pix_mask),
  .gen_ctrl  (gen_ctrl),
  .hsync_in  (hsync_in),
  .vsync_in  (vsync_in),
  .lut_addr  (lut_addr),
  .lut_rdata (lut_rdata),
  .rgb_out   (rgb_out),
  .hsync_out (hsync_out),
  .vsync_out (vsync_out),
  .wide_mode (wide_mode)
);

// File: tb/test_px_lookup_path.sv
`timescale 1ns/1ps
module test_px_lookup_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  width_req = 4'd8;
  logic [7:0]  pix_idx = '0, pix_mask = 8'hFF, gen_ctrl = 8'h03;
  logic        hsync_in = 1'b0, vsync_in = 1'b0;
  logic [7:0]  lut_addr;
  logic [23:0] lut_rdata = '0;
  logic [23:0] rgb_out;
  logic        hsync_out, vsync_out, mux_out;

  int total = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  px_lookup_path i_px_lookup_path (
    .clk(clk), .rst_n(rst_n), .width_req(width_req), .pix_idx(pix_idx),
    .pix_mask(pix_mask), .gen_ctrl(gen_ctrl), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .lut_addr(lut_addr), .lut_rdata(lut_rdata),
    .rgb_out(rgb_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .mux_out(mux_out)
  );

  // colour table contents, computed; upper bits of every byte vary
  function automatic int tbl_byte(int a, int ch);
    case (ch)
      2:       return (a * 37 + 11) % 256;
      1:       return (a * 91 + 200) % 256;
      default: return 255 - ((a * 3) % 256);
    endcase
  endfunction
  function automatic logic [23:0] tbl_word(int a);
    return 24'(tbl_byte(a, 2) * 65536 + tbl_byte(a, 1) * 256 + tbl_byte(a, 0));
  endfunction
  function automatic int widen(int c);
    return (c % 64) * 4 + (c / 16) % 4;
  endfunction
  function automatic logic [23:0] model_rgb(int a, bit full);
    int r = tbl_byte(a, 2), g = tbl_byte(a, 1), b = tbl_byte(a, 0);
    if (!full) begin r = widen(r); g = widen(g); b = widen(b); end
    return 24'(r * 65536 + g * 256 + b);
  endfunction
  function automatic logic sync_model(logic s, logic p);
    return 1'((int'(s) + int'(p) + 1) % 2);
  endfunction

  // external synchronous table
  always @(posedge clk) lut_rdata <= tbl_word(int'(lut_addr));

  // reference model, two-deep
  bit          m_full;
  int          settle = 0;
  logic [23:0] m_rgb_nxt = '0, m_rgb_cur = '0;
  logic        m_hs_nxt = 0, m_hs_cur = 0, m_vs_nxt = 0, m_vs_cur = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_full = (width_req == 4'd8);
      settle = 0;
      m_rgb_nxt = '0; m_rgb_cur = '0;
      m_hs_nxt = 0; m_hs_cur = 0; m_vs_nxt = 0; m_vs_cur = 0;
    end else begin
      m_rgb_cur = m_rgb_nxt; m_hs_cur = m_hs_nxt; m_vs_cur = m_vs_nxt;
      m_rgb_nxt = model_rgb(int'(pix_idx & pix_mask), m_full);
      m_hs_nxt  = sync_model(hsync_in, gen_ctrl[0]);
      m_vs_nxt  = sync_model(vsync_in, gen_ctrl[1]);
      if (settle < 10) settle++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 address", 32'(lut_addr), 32'(pix_idx & pix_mask));
    chk("R7 static pin", 32'(mux_out), 32'(gen_ctrl[7]));
    if (!rst_n) begin
      chk("R9 rgb in reset", 32'(rgb_out), 0);
      chk("R9 syncs in reset", {30'd0, vsync_out, hsync_out}, 0);
    end else if (settle >= 2) begin
      chk(m_full ? "R2/R4/R8 rgb" : "R2/R3/R8 rgb", 32'(rgb_out), 32'(m_rgb_cur));
      chk("R5/R8 hsync", 32'(hsync_out), 32'(m_hs_cur));
      chk("R6/R8 vsync", 32'(vsync_out), 32'(m_vs_cur));
    end
  endtask

  task automatic step(input logic [7:0] p, input logic [7:0] m, input logic [7:0] c,
                      input logic h, input logic v);
    @(negedge clk);
    compare_all();
    pix_idx = p; pix_mask = m; gen_ctrl = c; hsync_in = h; vsync_in = v;
    if (rst_n) width_req = 4'($urandom);     // R2: ignored outside reset
  endtask

  task automatic do_reset(input logic [3:0] wr);
    @(negedge clk);
    rst_n = 0; width_req = wr; hsync_in = 1; vsync_in = 1; gen_ctrl = 8'h03;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare_all();
    end
    rst_n = 1;
  endtask

  task automatic random_run(input int n, input logic [7:0] m, input bit vary_ctrl);
    for (int i = 0; i < n; i++)
      step(8'($urandom), m, vary_ctrl ? 8'($urandom) : 8'h03,
           1'($urandom), 1'($urandom));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    // full-byte session
    do_reset(4'd8);
    random_run(200, 8'hFF, 0);
    random_run(80, 8'h0F, 0);
    random_run(80, 8'hF0, 0);
    random_run(40, 8'h00, 0);
    random_run(200, 8'hFF, 1);
    for (int c = 0; c < 4; c++) random_run(40, 8'hFF, 0) ;
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 20; i++)
        step(8'($urandom), 8'hFF, {c[0], 5'd0, c[1:0]}, 1'($urandom), 1'($urandom));

    // R8: single-cycle hsync pulse appears after exactly two edges
    for (int i = 0; i < 4; i++) step(8'h10, 8'hFF, 8'h03, 0, 0);
    step(8'h10, 8'hFF, 8'h03, 1, 0);
    @(negedge clk); chk("R8 pulse not early", 32'(hsync_out), 0);
    hsync_in = 0;
    @(negedge clk); chk("R8 pulse arrives", 32'(hsync_out), 1);
    @(negedge clk); chk("R8 pulse one wide", 32'(hsync_out), 0);

    // unsupported request falls back to narrow
    do_reset(4'd7);
    for (int i = 0; i < 4; i++) step(8'hC7, 8'hFF, 8'h03, 0, 0);
    @(negedge clk);
    chk("R2 width 7 gives narrow", 32'(rgb_out), 32'(model_rgb(8'hC7, 0)));
    random_run(300, 8'hFF, 1);
    random_run(60, 8'h3C, 0);

    // explicit narrow request
    do_reset(4'd6);
    random_run(200, 8'hFF, 1);

    // back to full bytes
    do_reset(4'd8);
    for (int i = 0; i < 4; i++) step(8'hC7, 8'hFF, 8'h00, 0, 0);
    @(negedge clk);
    chk("R4 full after reset", 32'(rgb_out), 32'(tbl_word(8'hC7)));
    chk("R5 inverted idle", 32'(hsync_out), 1);
    chk("R6 inverted idle", 32'(vsync_out), 1);
    random_run(200, 8'hFF, 1);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule